// File: doc/BRIEF.md
# First-Order Delta-Sigma Pulse Modulator

This block converts an unsigned digital level into a single-bit pulse stream. Over time, the share of clock cycles in which the stream is high tracks the input level as a fraction of full scale. An external RC low-pass filter averages the stream to an analog voltage. A typical use is as the reference source for a comparator-based successive search.

The block is a first-order loop. A signed accumulator, two bits wider than the input, adds a feedback-corrected copy of the input on every clock. The correction is built only from wiring: two copies of the accumulator's top bit are placed above the input word. When the top bit is clear this adds the level. When it is set this adds the level minus full scale.

The top bit is registered to form the output pulse. Reset places the accumulator at the state that a zero input holds. A level that starts at zero therefore produces no start-up glitch. For full resolution the level should be held for 2^N clocks between changes.

Top module: `dsm_dac_modulator`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator loads 2^N (binary 01 followed by N zeros) and `pulse` loads 0, so `pulse` reads 0 after that edge.
- R2: After reset, with `level` held at 0, `pulse` stays 0 on every cycle.
- R3: On each rising edge with `rst` low, the accumulator becomes its old value plus the (N+2)-bit word formed by two copies of the accumulator's top bit (bit N+1) followed by `level`, taken modulo 2^(N+2). The bit order is: top bit, top bit, then `level` bits N-1 down to 0.
- R4: On each rising edge with `rst` low, `pulse` takes the value of the accumulator's top bit as it was before that edge, giving one cycle of latency.
- R5: For a constant `level` D, any 2^N consecutive `pulse` samples taken after D is applied contain D high cycles, plus or minus one.
- R6: With `level` at all ones (2^N-1), a 2^N-cycle window holds at most two low cycles.
- R7: Out of reset, the accumulator stays in the range 2^N to 3*2^N-2 inclusive, so the signed sum never wraps.
- R8: When reset arrives in the same cycle as a change of `level`, reset wins. The state returns to that of R1, and the next zero-level window shows no pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the accumulator and output flop |
| rst | input | 1 | Synchronous active-high reset |
| level | input | N | Unsigned level to encode; full scale is 2^N-1 |
| pulse | output | 1 | Registered pulse stream for the external filter |

## Verification
Two events can fall on the same edge: a change of the input level, and the feedback step in which the accumulator's top bit turns the addition into a subtraction. Random levels that change every few cycles force both cases, often on the very edge where the top bit flips. Each output sample is judged against a bench model of the R3 recurrence. A synchronous reset is also issued in the same cycle as a level change, and is judged by a following zero-level window that must stay silent.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Default input width of the modulator.
    localparam int unsigned DSM_LEVEL_W_DEF = 9;

    // Number of guard bits the accumulator carries above the level.
    localparam int unsigned DSM_GUARD_W = 2;

    // Role of the accumulator's top bit in the feedback path.
    typedef enum logic {
        FB_ADD_LEVEL = 1'b0,
        FB_SUB_SCALE = 1'b1
    } dsm_fb_e;

    // Decode the top accumulator bit into a feedback mode.
    function automatic dsm_fb_e dsm_fb_mode(input logic top_bit);
        return top_bit ? FB_SUB_SCALE : FB_ADD_LEVEL;
    endfunction

endpackage

// File: rtl/dsm_delta.sv
module dsm_delta
    import dsm_pkg::*;
#(
    parameter int unsigned N = DSM_LEVEL_W_DEF,
    localparam int unsigned W = N + DSM_GUARD_W
) (
    input  logic [N-1:0] level,
    input  dsm_fb_e      fb_mode,
    output logic [W-1:0] delta
);

    // Guard bits copy the feedback sign; no carry chain is needed.
    logic [DSM_GUARD_W-1:0] guard;

    always_comb begin
        guard = {DSM_GUARD_W{fb_mode == FB_SUB_SCALE}};
        delta = {guard, level};
    end

endmodule

// File: rtl/dsm_sigma.sv
module dsm_sigma
    import dsm_pkg::*;
#(
    parameter int unsigned N = DSM_LEVEL_W_DEF,
    localparam int unsigned W = N + DSM_GUARD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] delta,
    output logic [W-1:0] acc
);

    // The state that a zero level holds: 01 followed by N zeros.
    localparam logic [W-1:0] ACC_RST = {2'b01, {N{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= ACC_RST;
        end else begin
            acc <= acc + delta;
        end
    end

endmodule

// File: rtl/dsm_pulse_ff.sv
module dsm_pulse_ff (
    input  logic clk,
    input  logic rst,
    input  logic top_bit,
    output logic pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= top_bit;
        end
    end

endmodule

// File: rtl/dsm_dac_modulator.sv
module dsm_dac_modulator
    import dsm_pkg::*;
#(
    parameter int unsigned N = DSM_LEVEL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    output logic         pulse
);

    localparam int unsigned W = N + DSM_GUARD_W;

    logic [W-1:0] acc_q;
    logic [W-1:0] delta;
    dsm_fb_e      fb_mode;

    assign fb_mode = dsm_fb_mode(acc_q[W-1]);

    dsm_delta #(.N(N)) u_delta (
        .level   (level),
        .fb_mode (fb_mode),
        .delta   (delta)
    );

    dsm_sigma #(.N(N)) u_sigma (
        .clk   (clk),
        .rst   (rst),
        .delta (delta),
        .acc   (acc_q)
    );

    dsm_pulse_ff u_pulse (
        .clk     (clk),
        .rst     (rst),
        .top_bit (acc_q[W-1]),
        .pulse   (pulse)
    );

endmodule

// File: rtl/dsm_dac_modulator_chk.sv
module dsm_dac_modulator_chk
    import dsm_pkg::*;
#(
    parameter int unsigned N = DSM_LEVEL_W_DEF,
    localparam int unsigned W = N + DSM_GUARD_W
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] level,
    input logic [W-1:0] acc,
    input logic         pulse
);

    localparam logic [W-1:0] ACC_LO = {2'b01, {N{1'b0}}};
    localparam logic [W-1:0] ACC_HI = W'(3 * (2 ** N) - 2);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (acc == ACC_LO && pulse == 1'b0));

    // R7
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        (acc >= ACC_LO && acc <= ACC_HI));

    // R4
    pulse_lag_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pulse == $past(acc[W-1]));

    // R2
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && !acc[W-1]) |=> $stable(acc));

    // R3
    rise_when_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !acc[W-1] |=> acc >= $past(acc));

endmodule

bind dsm_dac_modulator dsm_dac_modulator_chk #(.N(N)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .level (level),
    .acc   (acc_q),
    .pulse (pulse)
);

// File: tb/dsm_dac_modulator_tb.sv
module dsm_dac_modulator_tb;

    localparam int N          = 9;
    localparam int W          = N + 2;
    localparam int WIN        = 1 << N;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] level = '0;
    logic         pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model built from R1, R3 and R4.
    logic [W-1:0] m_acc;
    logic         m_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsm_dac_modulator #(.N(N)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .pulse (pulse)
    );

    function automatic logic [W-1:0] next_acc(logic [W-1:0] a, logic [N-1:0] d);
        return a + {a[W-1], a[W-1], d};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc   <= {2'b01, {N{1'b0}}};
            m_pulse <= 1'b0;
        end else begin
            m_pulse <= m_acc[W-1];
            m_acc   <= next_acc(m_acc, level);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sample one cycle at the negative edge and compare with the model (R3, R4).
    task automatic step_cmp(output int hi);
        @(negedge clk);
        check("R3 R4 pulse", int'(pulse), int'(m_pulse));
        hi = int'(pulse);
    endtask

    // Hold a level for one full window and count high samples.
    task automatic run_window(input int d, output int cnt);
        int hi;
        level = N'(d);
        cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            step_cmp(hi);
            cnt += hi;
        end
    endtask

    task automatic density(input int d);
        int cnt;
        int diff;
        run_window(d, cnt);
        diff = cnt - d;
        if (diff < 0) diff = -diff;
        // R5
        check("R5 density error bound", (diff <= 1) ? 1 : 0, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        int hi;
        void'($urandom(32'd2718));

        repeat (3) @(negedge clk);
        // R1
        check("R1 pulse in reset", int'(pulse), 0);
        rst = 1'b0;

        // R2: zero level gives silence.
        run_window(0, cnt);
        check("R2 zero level highs", cnt, 0);

        // R5 on directed corners.
        density(1);
        density(WIN / 2);
        density(WIN / 2 - 1);
        density(3);

        // R6: full scale.
        run_window(WIN - 1, cnt);
        check("R6 full scale lows", (WIN - cnt <= 2) ? 1 : 0, 1);

        // R5 on random levels.
        for (int k = 0; k < 6; k++) begin
            density(int'($urandom % WIN));
        end

        // R3: level changing every few cycles, hitting feedback flips.
        for (int k = 0; k < 400; k++) begin
            level = N'($urandom);
            repeat (1 + ($urandom % 5)) step_cmp(hi);
        end

        // R8: reset and a level change on the same edge.
        level = N'(WIN - 1);
        repeat (37) step_cmp(hi);
        rst   = 1'b1;
        level = N'(WIN / 3);
        @(negedge clk);
        check("R8 pulse after reset edge", int'(pulse), 0);
        rst = 1'b0;
        run_window(0, cnt);
        check("R8 zero window after reset", cnt, 0);

        // R1: reset held over several cycles keeps output low.
        level = N'(WIN - 1);
        rst = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R1 pulse held in reset", int'(pulse), 0);
        end
        rst = 1'b0;
        density(WIN - 2);

        finish_run();
    end

endmodule